// File: doc/BRIEF.md
# Multiplexed Slow Peripheral Bus Controller

This block connects a host request port to a narrow external bus that is eight bits wide and carries both address and data. When the host raises a request, the controller selects one of two attached devices and sends the device offset over the data lines in three consecutive cycles. Each cycle pulses its own latch enable, so that external registers can capture that piece of the address. The controller then writes the data byte, or turns the bus around and samples the byte the device returns. Finally it hands a one-cycle grant back to the host.

The 64 MB window is split into two 32 MB halves, one for each device select. For each select, a configuration bit chooses how the data phase ends. A fixed-timed device gets a programmed number of wait cycles. A self-timed device ends the phase by pulling an active-low acknowledge, and a 255-cycle guard stops the transfer with an error if that acknowledge never arrives. The full 25-bit offset is forwarded as given. A device smaller than 32 MB ignores its unused upper bits, so its contents repeat every device-size step.

Top module: `slow_bus_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, grant=0, tmo_err=0, cs_n=2'b11, latch_en=0, bus_oe=0, oe_n=1 and we_n=1.
- R2: Host address bit 25 picks the select: 0 asserts cs_n[0] and 1 asserts cs_n[1] (both active low). At most one select is low, and it stays low unchanged from the first address cycle to the last data cycle.
- R3: In the three cycles after a request is accepted in idle, bus_out carries host address bits [23:16], then [15:8], then [7:0], with bus_oe=1 and latch_en equal to 3'b100, 3'b010 and 3'b001 in turn. The enables are never more than one-hot.
- R4: addr_msb carries host address bit 24 through the address and data phases. The data phase starts in the cycle right after the low byte, with latch_en=0. During a write's data phase the controller drives the write byte with bus_oe=1 and we_n=0.
- R5: During a read's data phase, oe_n=0 and bus_oe=0. oe_n is high in every other cycle.
- R6: On a fixed-timed select (cfg_self bit 0), the data phase lasts exactly cfg_wait+1 cycles, where cfg_wait is 4 bits per select with select 0 in bits [3:0]. Read data is sampled from bus_in on the last of those cycles.
- R7: On a self-timed select (cfg_self bit 1), the data phase ends with the first data cycle in which ack_n is low. Read data is sampled in that cycle.
- R8: If a self-timed data phase sees no acknowledge in 255 cycles, the transfer ends after the 255th cycle and tmo_err is 1 in the grant cycle. An acknowledge in the 255th cycle still completes normally with tmo_err=0.
- R9: grant is a one-cycle pulse in the cycle after the last data cycle. rdata holds the read byte in that cycle, all selects and strobes are inactive, and tmo_err is only ever high together with grant.
- R10: The offset reaches the bus unmodified, so a 4 MB device that decodes only 22 bits returns identical bytes for offsets that differ by 4 MB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, held until grant |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 26 | Host byte address; bit 25 picks the device |
| wdata | input | 8 | Write byte |
| cfg_self | input | 2 | Per select: 1 = self-timed, 0 = fixed-timed |
| cfg_wait | input | 8 | Per-select wait count, 4 bits each |
| grant | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read byte, valid with grant |
| tmo_err | output | 1 | Acknowledge timeout, valid with grant |
| bus_out | output | 8 | Byte driven onto the shared lines |
| bus_oe | output | 1 | Driver enable for bus_out |
| bus_in | input | 8 | Byte sampled from the shared lines |
| latch_en | output | 3 | One-hot address latch strobes (high, mid, low) |
| addr_msb | output | 1 | Offset bit 24 on its own pin |
| cs_n | output | 2 | Active-low device selects |
| oe_n | output | 1 | Active-low read output enable |
| we_n | output | 1 | Active-low write strobe |
| ack_n | input | 1 | Active-low acknowledge from self-timed devices |

## Verification
The bench builds the block with its default parameters: two selects, three address bytes, a 4-bit wait field and a 255-cycle acknowledge guard. With these values the longest fixed wait (15) and the full timeout window both fit in a few hundred cycles. The bench therefore runs an acknowledge in the very last allowed cycle next to a true timeout. Its device model rebuilds the offset from the latch strobes and decodes only 22 bits for select 0, which brings the 4 MB aliasing within reach.

// File: rtl/slowbus_pkg.sv
package slowbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } sb_state_e;
endpackage

// File: rtl/slowbus_dev_decode.sv
module slowbus_dev_decode #(
  parameter int N_DEV  = 2,
  parameter int WAIT_W = 4,
  parameter int SEL_W  = 1
) (
  input  logic [SEL_W-1:0]        sel,
  input  logic [N_DEV-1:0]        cfg_self,
  input  logic [N_DEV*WAIT_W-1:0] cfg_wait,
  output logic [N_DEV-1:0]        cs_n,
  output logic                    self_t,
  output logic [WAIT_W-1:0]       wait_v
);
  // one active-low select per device
  for (genvar g = 0; g < N_DEV; g++) begin : g_cs
    assign cs_n[g] = (sel != SEL_W'(g));
  end

  assign self_t = cfg_self[sel];
  assign wait_v = cfg_wait[sel*WAIT_W +: WAIT_W];
endmodule

// File: rtl/slowbus_addr_seq.sv
module slowbus_addr_seq #(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 3,
  parameter int PH_W    = 2
) (
  input  logic [N_BYTES*BYTE_W-1:0] low_part,
  input  logic [PH_W-1:0]           idx,
  output logic [BYTE_W-1:0]         byte_o,
  output logic [N_BYTES-1:0]        le_o
);
  logic [BYTE_W-1:0] piece [N_BYTES];
  logic [N_BYTES-1:0] hit;

  // piece 0 is the most significant byte
  for (genvar g = 0; g < N_BYTES; g++) begin : g_piece
    assign piece[g] = low_part[(N_BYTES-g)*BYTE_W-1 -: BYTE_W];
    assign hit[g]   = (idx == PH_W'(g));
  end

  always_comb begin
    byte_o = '0;
    le_o   = '0;
    for (int i = 0; i < N_BYTES; i++) begin
      if (hit[i]) begin
        byte_o             = piece[i];
        le_o[N_BYTES-1-i]  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/slowbus_wait_timer.sv
module slowbus_wait_timer #(
  parameter int WAIT_W     = 4,
  parameter int TMO_CYCLES = 255,
  parameter int TMO_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              self_t,
  input  logic [WAIT_W-1:0] lim,
  input  logic              ack_n,
  output logic              fin,
  output logic              tmo
);
  logic [TMO_W-1:0] cnt;
  logic [TMO_W-1:0] lim_x;
  logic             at_lim;
  logic             at_guard;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign lim_x    = TMO_W'(lim);
  assign at_lim   = (cnt == lim_x);
  assign at_guard = (cnt == TMO_W'(TMO_CYCLES-1));

  assign fin = self_t ? (!ack_n || at_guard) : at_lim;
  assign tmo = self_t && ack_n && at_guard;
endmodule

// File: rtl/slow_bus_ctrl.sv
module slow_bus_ctrl #(
  parameter int ADDR_W     = 26,
  parameter int BYTE_W     = 8,
  parameter int N_BYTES    = 3,
  parameter int WAIT_W     = 4,
  parameter int TMO_CYCLES = 255
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BYTE_W-1:0]           wdata,
  input  logic [1:0]                  cfg_self,
  input  logic [2*WAIT_W-1:0]         cfg_wait,
  output logic                        grant,
  output logic [BYTE_W-1:0]           rdata,
  output logic                        tmo_err,
  output logic [BYTE_W-1:0]           bus_out,
  output logic                        bus_oe,
  input  logic [BYTE_W-1:0]           bus_in,
  output logic [N_BYTES-1:0]          latch_en,
  output logic                        addr_msb,
  output logic [1:0]                  cs_n,
  output logic                        oe_n,
  output logic                        we_n,
  input  logic                        ack_n
);
  import slowbus_pkg::*;

  localparam int DEV_AW = ADDR_W - 1;
  localparam int N_DEV  = 2;
  localparam int SEL_W  = 1;
  localparam int LAT_W  = N_BYTES * BYTE_W;
  localparam int PH_W   = $clog2(N_BYTES + 1);
  localparam int TMO_W  = $clog2(TMO_CYCLES + 1);

  sb_state_e           st;
  logic [PH_W-1:0]     ph;
  logic [DEV_AW-1:0]   a_q;
  logic                wr_q;
  logic [BYTE_W-1:0]   wd_q;
  logic                self_q;
  logic [WAIT_W-1:0]   wait_q;

  logic [N_DEV-1:0]    dec_cs;
  logic                dec_self;
  logic [WAIT_W-1:0]   dec_wait;
  logic [LAT_W-1:0]    seq_src;
  logic [PH_W-1:0]     seq_idx;
  logic [BYTE_W-1:0]   seq_byte;
  logic [N_BYTES-1:0]  seq_le;
  logic                tm_fin;
  logic                tm_tmo;

  slowbus_dev_decode #(.N_DEV(N_DEV), .WAIT_W(WAIT_W), .SEL_W(SEL_W)) u_dec (
    .sel      (addr[ADDR_W-1 -: SEL_W]),
    .cfg_self (cfg_self),
    .cfg_wait (cfg_wait),
    .cs_n     (dec_cs),
    .self_t   (dec_self),
    .wait_v   (dec_wait)
  );

  // in idle the first byte comes straight from the request
  assign seq_src = (st == ST_IDLE) ? addr[LAT_W-1:0] : a_q[LAT_W-1:0];
  assign seq_idx = (st == ST_IDLE) ? '0 : ph + 1'b1;

  slowbus_addr_seq #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES), .PH_W(PH_W)) u_seq (
    .low_part (seq_src),
    .idx      (seq_idx),
    .byte_o   (seq_byte),
    .le_o     (seq_le)
  );

  slowbus_wait_timer #(.WAIT_W(WAIT_W), .TMO_CYCLES(TMO_CYCLES), .TMO_W(TMO_W)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .run    (st == ST_DATA),
    .self_t (self_q),
    .lim    (wait_q),
    .ack_n  (ack_n),
    .fin    (tm_fin),
    .tmo    (tm_tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ph       <= '0;
      a_q      <= '0;
      wr_q     <= 1'b0;
      wd_q     <= '0;
      self_q   <= 1'b0;
      wait_q   <= '0;
      grant    <= 1'b0;
      rdata    <= '0;
      tmo_err  <= 1'b0;
      bus_out  <= '0;
      bus_oe   <= 1'b0;
      latch_en <= '0;
      addr_msb <= 1'b0;
      cs_n     <= '1;
      oe_n     <= 1'b1;
      we_n     <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          grant   <= 1'b0;
          tmo_err <= 1'b0;
          if (req) begin
            st       <= ST_ADDR;
            ph       <= '0;
            a_q      <= addr[DEV_AW-1:0];
            wr_q     <= wr;
            wd_q     <= wdata;
            self_q   <= dec_self;
            wait_q   <= dec_wait;
            cs_n     <= dec_cs;
            addr_msb <= addr[DEV_AW-1];
            bus_out  <= seq_byte;
            latch_en <= seq_le;
            bus_oe   <= 1'b1;
          end
        end
        ST_ADDR: begin
          if (ph == PH_W'(N_BYTES-1)) begin
            st       <= ST_DATA;
            latch_en <= '0;
            bus_out  <= wr_q ? wd_q : '0;
            bus_oe   <= wr_q;
            we_n     <= !wr_q;
            oe_n     <= wr_q;
          end else begin
            ph       <= ph + 1'b1;
            bus_out  <= seq_byte;
            latch_en <= seq_le;
          end
        end
        ST_DATA: begin
          if (tm_fin) begin
            st       <= ST_DONE;
            grant    <= 1'b1;
            tmo_err  <= tm_tmo;
            if (!wr_q) rdata <= bus_in;
            cs_n     <= '1;
            addr_msb <= 1'b0;
            bus_out  <= '0;
            bus_oe   <= 1'b0;
            we_n     <= 1'b1;
            oe_n     <= 1'b1;
          end
        end
        ST_DONE: begin
          grant   <= 1'b0;
          tmo_err <= 1'b0;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slowbus_ctrl_chk.sv
module slowbus_ctrl_chk #(
  parameter int N_BYTES = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               grant,
  input logic               tmo_err,
  input logic               bus_oe,
  input logic [N_BYTES-1:0] latch_en,
  input logic [1:0]         cs_n,
  input logic               oe_n,
  input logic               we_n
);
  AST_LATCH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(latch_en)); // R3
  AST_LATCH_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (latch_en[N_BYTES-1:1] != '0) |=> (latch_en == ($past(latch_en) >> 1))); // R3
  AST_DATA_FOLLOWS_ADDR: assert property (@(posedge clk) disable iff (rst)
    (latch_en == N_BYTES'(1)) |=> (latch_en == '0 && (!oe_n || !we_n))); // R4
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !bus_oe); // R5
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1); // R2
  AST_SELECT_STEADY: assert property (@(posedge clk) disable iff (rst)
    (cs_n != 2'b11 && $past(cs_n) != 2'b11) |-> $stable(cs_n)); // R2
  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (rst)
    grant |=> !grant); // R9
  AST_GRANT_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
    grant |-> (cs_n == 2'b11 && oe_n && we_n && !bus_oe)); // R9
  AST_TMO_WITH_GRANT: assert property (@(posedge clk) disable iff (rst)
    tmo_err |-> grant); // R8
endmodule

bind slow_bus_ctrl slowbus_ctrl_chk #(.N_BYTES(N_BYTES)) u_chk (.*);

// File: tb/sim_slow_bus_ctrl.sv
`timescale 1ns/1ps
module sim_slow_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic [25:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [1:0]  cfg_self = 2'b10;
  logic [7:0]  cfg_wait = '0;
  logic        grant;
  logic [7:0]  rdata;
  logic        tmo_err;
  logic [7:0]  bus_out;
  logic        bus_oe;
  logic [7:0]  bus_in;
  logic [2:0]  latch_en;
  logic        addr_msb;
  logic [1:0]  cs_n;
  logic        oe_n;
  logic        we_n;
  logic        ack_n = 1'b1;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  slow_bus_ctrl u0 (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .cfg_self(cfg_self), .cfg_wait(cfg_wait), .grant(grant), .rdata(rdata),
    .tmo_err(tmo_err), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
    .latch_en(latch_en), .addr_msb(addr_msb), .cs_n(cs_n), .oe_n(oe_n),
    .we_n(we_n), .ack_n(ack_n)
  );

  // external latches and device model
  logic [7:0] lat_h = '0, lat_m = '0, lat_l = '0;
  always @(posedge clk) begin
    if (latch_en[2]) lat_h <= bus_out;
    if (latch_en[1]) lat_m <= bus_out;
    if (latch_en[0]) lat_l <= bus_out;
  end

  function automatic logic [7:0] dev_byte(input logic [24:0] x);
    logic [8:0] s;
    s = {1'b0, x[7:0]} + {1'b0, x[15:8]} * 9'd3 + x[24:16];
    return s[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [24:0] dev_view(input logic sel, input logic [24:0] x);
    return sel ? x : (x & 25'h03F_FFFF);
  endfunction

  always_comb begin
    if (!cs_n[0])      bus_in = dev_byte(dev_view(1'b0, {addr_msb, lat_h, lat_m, lat_l}));
    else if (!cs_n[1]) bus_in = dev_byte(dev_view(1'b1, {addr_msb, lat_h, lat_m, lat_l}));
    else               bus_in = 8'h00;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  // one transfer; ackd < 0 means the device never acknowledges
  task automatic xfer(input logic w, input logic [25:0] a, input logic [7:0] wd,
                      input int ackd, output logic [7:0] got);
    logic       sel;
    logic       self_t;
    int         wt;
    int         g;
    int         cyc;
    logic [1:0] cs_exp;
    sel    = a[25];
    self_t = cfg_self[sel];
    wt     = sel ? int'(cfg_wait[7:4]) : int'(cfg_wait[3:0]);
    if (!self_t)        g = 5 + wt;
    else if (ackd >= 0) g = 5 + ackd;
    else                g = 4 + 255;
    cs_exp = sel ? 2'b01 : 2'b10;
    @(negedge clk);
    chk("R9 idle grant", grant, 0);
    chk("R9 idle select", cs_n, 2'b11);
    req = 1'b1; wr = w; addr = a; wdata = wd; ack_n = 1'b1;
    cyc = 0;
    got = '0;
    while (cyc < g) begin
      @(negedge clk);
      cyc++;
      if (cyc < g) begin
        chk("R2 select", cs_n, cs_exp);
        chk("R4 msb pin", addr_msb, a[24]);
        chk("R9 no early grant", grant, 0);
      end
      if (cyc <= 3) begin
        chk("R3 latch strobe", latch_en, 3'b100 >> (cyc - 1));
        chk("R3 address byte", bus_out, a[23 - 8*(cyc-1) -: 8]);
        chk("R3 drive", bus_oe, 1);
        chk("R5 oe idle", oe_n, 1);
      end else if (cyc < g) begin
        chk("R4 no strobe in data", latch_en, 0);
        if (w) begin
          chk("R4 write byte", bus_out, wd);
          chk("R4 write drive", bus_oe, 1);
          chk("R4 write strobe", we_n, 0);
          chk("R5 oe during write", oe_n, 1);
        end else begin
          chk("R5 read oe", oe_n, 0);
          chk("R5 read tristate", bus_oe, 0);
          chk("R5 no write strobe", we_n, 1);
        end
        ack_n = !(self_t && ackd >= 0 && (cyc - 4) == ackd);
      end else begin
        ack_n = 1'b1;
        chk(self_t ? "R7 R9 grant cycle" : "R6 R9 grant cycle", grant, 1);
        chk("R9 bus idle", {cs_n, oe_n, we_n, bus_oe, latch_en}, {2'b11, 1'b1, 1'b1, 1'b0, 3'b000});
        chk("R8 timeout flag", tmo_err, (self_t && ackd < 0) ? 1 : 0);
        if (!w && !(self_t && ackd < 0))
          chk("R6 R7 R10 read data", rdata, dev_byte(dev_view(sel, a[24:0])));
        got = rdata;
        req = 1'b0;
      end
    end
    @(negedge clk);
    chk("R9 grant single cycle", grant, 0);
    chk("R8 flag cleared", tmo_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r0;
    logic [7:0] r1;
    repeat (3) @(negedge clk);
    chk("R1 reset grant", grant, 0);
    chk("R1 reset outputs", {cs_n, oe_n, we_n, bus_oe, latch_en, tmo_err}, {2'b11, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0});
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {grant, cs_n, oe_n, we_n, bus_oe, latch_en}, {1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 3'b000});

    // select 0 fixed-timed, select 1 self-timed
    cfg_self = 2'b10;
    cfg_wait = 8'h70;
    xfer(1'b1, 26'h0123456, 8'hA5, -1, r0);           // R6 wait 0 write
    cfg_wait = 8'h73;
    xfer(1'b0, 26'h1ABCDEF, 8'h00, -1, r0);           // R6 wait 3 read, R4 msb=1
    cfg_wait = 8'h7F;
    xfer(1'b0, 26'h0F00F0F, 8'h00, -1, r0);           // R6 wait 15 read
    xfer(1'b0, 26'h3ABCDEF, 8'h00, 0, r0);            // R7 immediate ack
    xfer(1'b1, 26'h2345678, 8'h3C, 7, r0);            // R7 delayed ack write
    xfer(1'b0, 26'h2000001, 8'h00, -1, r0);           // R8 timeout
    xfer(1'b0, 26'h2FFFFFF, 8'h00, 254, r0);          // R8 ack in last allowed cycle
    // R10 aliasing on 4 MB device
    cfg_wait = 8'h71;
    xfer(1'b0, 26'h0000155, 8'h00, -1, r0);
    xfer(1'b0, 26'h0400155, 8'h00, -1, r1);
    chk("R10 alias repeat", r1, r0);
    xfer(1'b0, 26'h1C00155, 8'h00, -1, r1);
    chk("R10 alias high step", r1, r0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule